// File: doc/BRIEF.md
# Serial EEPROM Read Sequencer

This block reads a run of bytes from a four-wire serial EEPROM. The EEPROM sits behind a control word that software would otherwise toggle one bit at a time. A single start pulse carries a 16-bit byte offset and a byte count. The sequencer then opens access to the device with a two-step handshake on two separate control lines. It clocks out a read command and the address, clocks in the requested bytes, and closes access again with the mirrored two-step handshake.

Each byte read back goes out on a valid/ready byte stream. While a byte waits for the consumer, the serial clock is held low. A one-cycle done pulse marks the end of the transaction, and it comes only after access is fully closed. Every phase of the serial clock and every handshake step lasts `PHASE_CYC` system cycles, with a minimum of 2, so the device's setup and hold times can be met at any system clock rate.

Top module: `serial_rom_reader`

## Requirements
- R1: Reset state: `rom_clk_o` low, `rom_grant_o` low, `rom_park_o` high (access closed), `byte_valid_o` low, `done_o` low.
- R2: Opening access: `rom_grant_o` rises first, and `rom_park_o` falls exactly `PHASE_CYC` cycles later. `rom_clk_o` is low at both edges, and it stays low whenever access is not open (`rom_grant_o` high and `rom_park_o` low).
- R3: With a nonzero count, the first 24 bits clocked out are the read command 0x03, then `offset_i[15:8]`, then `offset_i[7:0]`. Each byte goes out most significant bit first, and the device samples each bit on the rising edge of `rom_clk_o`.
- R4: `rom_dout_o` changes only while `rom_clk_o` is low. It is set before the rising edge and holds its value for the whole high phase.
- R5: Input bits are sampled while `rom_clk_o` is high, in the last cycle of the high phase. Each sampled bit shifts into the LSB of the byte being built, so the first bit received becomes bit 7 of that byte.
- R6: Every high phase of `rom_clk_o` lasts exactly `PHASE_CYC` system cycles.
- R7: After the 24 header bits, exactly `8*count` further bits are clocked and exactly `count` bytes appear on the stream. No further command is sent. The device supplies consecutive addresses, modulo 2^16.
- R8: `byte_valid_o` stays high with `byte_data_o` stable until `byte_ready_i` is seen high. While a byte is pending, `rom_clk_o` stays low.
- R9: Closing access: `rom_park_o` rises first, and `rom_grant_o` falls exactly `PHASE_CYC` cycles later. `done_o` pulses for one cycle in the cycle the closed state is reached, and exactly once per transaction.
- R10: A `start_i` pulse during a transaction is ignored. The offset, the count and the number of done pulses are those of the first request.
- R11: A count of zero performs the open and close handshakes, clocks no bits, emits no bytes and still pulses `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse; taken only when idle |
| offset_i | input | 16 | Byte offset of the first byte to read |
| count_i | input | CNT_W | Number of bytes to read |
| byte_ready_i | input | 1 | Consumer accepts the presented byte |
| rom_din_i | input | 1 | Serial data from the EEPROM |
| rom_clk_o | output | 1 | Serial clock to the EEPROM |
| rom_dout_o | output | 1 | Serial data to the EEPROM |
| rom_grant_o | output | 1 | Access line, high while access is granted |
| rom_park_o | output | 1 | Access line, high while the device is parked |
| byte_valid_o | output | 1 | A read byte is presented |
| byte_data_o | output | 8 | The read byte |
| done_o | output | 1 | One-cycle pulse after access is closed |

## Verification
Most faults in the shift engine show up at the ports within one byte time (16·PHASE_CYC cycles). A bit-counter error shifts or garbles the 24-bit header the bench decodes from the wire. It also changes the total number of clock pulses, and it bit-slips every returned byte against the arithmetic memory model. A fault in the sequencing state appears as a handshake edge out of order or a gap other than PHASE_CYC cycles. It can also appear as a missing or doubled done pulse, or a byte count that differs from the request, visible by the end of the transaction. Offsets that cross 0xFFFF, a count of zero, three backpressure patterns and a start injected mid-transaction cover the remaining corners.

// File: rtl/srr_pkg.sv
package srr_pkg;

  localparam logic [7:0] ROM_READ_OP = 8'h03;

  typedef enum logic [3:0] {
    S_IDLE,
    S_OPEN1,
    S_OPEN2,
    S_HDR,
    S_HDR_WAIT,
    S_RD,
    S_RD_WAIT,
    S_PRESENT,
    S_CLOSE
  } seq_e;

  typedef enum logic {PH_LOW, PH_HIGH} phase_e;

  // Header byte by position: command, offset high, offset low.
  function automatic logic [7:0] hdr_byte(input logic [1:0] idx,
                                          input logic [15:0] off);
    case (idx)
      2'd0:    return ROM_READ_OP;
      2'd1:    return off[15:8];
      default: return off[7:0];
    endcase
  endfunction

  // New bit enters at the LSB; the byte is built MSB first.
  function automatic logic [7:0] shift_in(input logic [7:0] acc, input logic b);
    return {acc[6:0], b};
  endfunction

  // Move the next outgoing bit into the MSB.
  function automatic logic [7:0] shift_out(input logic [7:0] acc);
    return {acc[6:0], 1'b0};
  endfunction

endpackage

// File: rtl/srr_phase_timer.sv
module srr_phase_timer #(
  parameter int PHASE_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic tick_o
);
  localparam int W = $clog2(PHASE_CYC + 1);
  localparam logic [W-1:0] LAST = W'(PHASE_CYC - 1);

  logic [W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  // Phases are at least two cycles long, so ticks never come back to back.
  assert_tick_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);

endmodule

// File: rtl/srr_bit_engine.sv
module srr_bit_engine
  import srr_pkg::*;
#(
  parameter int PHASE_CYC = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go_i,
  input  logic       rd_i,
  input  logic [7:0] tx_byte_i,
  input  logic       rom_din_i,
  output logic       rom_clk_o,
  output logic       rom_dout_o,
  output logic [7:0] rx_byte_o,
  output logic       done_o
);
  logic       busy_q;
  phase_e     phase_q;
  logic [2:0] bidx_q;
  logic [7:0] shreg_q;
  logic       rd_q;
  logic       clk_q;
  logic       dout_q;
  logic       done_q;
  logic       tick;

  srr_phase_timer #(.PHASE_CYC(PHASE_CYC)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (busy_q),
    .tick_o (tick)
  );

  wire last_bit  = (bidx_q == 3'd7);
  wire fall_edge = busy_q && tick && (phase_q == PH_HIGH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      phase_q <= PH_LOW;
      bidx_q  <= '0;
      shreg_q <= '0;
      rd_q    <= 1'b0;
      clk_q   <= 1'b0;
      dout_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q && go_i) begin
        busy_q  <= 1'b1;
        phase_q <= PH_LOW;
        bidx_q  <= '0;
        rd_q    <= rd_i;
        shreg_q <= tx_byte_i;
        dout_q  <= rd_i ? 1'b0 : tx_byte_i[7];
      end else if (busy_q && tick) begin
        if (phase_q == PH_LOW) begin
          phase_q <= PH_HIGH;
          clk_q   <= 1'b1;
        end else begin
          clk_q   <= 1'b0;
          shreg_q <= rd_q ? shift_in(shreg_q, rom_din_i) : shift_out(shreg_q);
          if (last_bit) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else begin
            bidx_q  <= bidx_q + 1'b1;
            phase_q <= PH_LOW;
            if (!rd_q) dout_q <= shreg_q[6];
          end
        end
      end
    end
  end

  assign rom_clk_o  = clk_q;
  assign rom_dout_o = dout_q;
  assign rx_byte_o  = shreg_q;
  assign done_o     = done_q;

  // Data-out never moves while the clock is high.
  assert_dout_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rom_clk_o |-> $stable(rom_dout_o));

  // The clock only pulses while a byte is in flight.
  assert_clk_in_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rom_clk_o |-> busy_q);

  // A byte completes on the cycle after a falling clock edge, with the clock low.
  assert_done_after_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fall_edge && last_bit |=> done_o && !rom_clk_o);

endmodule

// File: rtl/serial_rom_reader.sv
module serial_rom_reader
  import srr_pkg::*;
#(
  parameter int PHASE_CYC = 4,
  parameter int CNT_W     = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [15:0]      offset_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             byte_ready_i,
  input  logic             rom_din_i,
  output logic             rom_clk_o,
  output logic             rom_dout_o,
  output logic             rom_grant_o,
  output logic             rom_park_o,
  output logic             byte_valid_o,
  output logic [7:0]       byte_data_o,
  output logic             done_o
);
  localparam logic [CNT_W-1:0] ONE_LEFT = CNT_W'(1);

  seq_e             st_q;
  logic [15:0]      off_q;
  logic [CNT_W-1:0] left_q;
  logic [1:0]       hidx_q;
  logic             grant_q;
  logic             park_q;
  logic             valid_q;
  logic             done_q;
  logic [7:0]       data_q;

  // Named internal events.
  logic hs_tick;
  logic eng_go;
  logic eng_rd;
  logic eng_done;
  logic [7:0] eng_rx;
  logic [7:0] eng_tx;

  wire hs_run     = (st_q == S_OPEN1) || (st_q == S_OPEN2) || (st_q == S_CLOSE);
  wire accept     = valid_q && byte_ready_i;
  wire last_byte  = (left_q == ONE_LEFT);
  wire start_take = start_i && (st_q == S_IDLE);
  wire access_open = grant_q && !park_q;

  assign eng_go = (st_q == S_HDR) || (st_q == S_RD);
  assign eng_rd = (st_q == S_RD);
  assign eng_tx = hdr_byte(hidx_q, off_q);

  srr_phase_timer #(.PHASE_CYC(PHASE_CYC)) u_hs_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (hs_run),
    .tick_o (hs_tick)
  );

  srr_bit_engine #(.PHASE_CYC(PHASE_CYC)) u_engine (
    .clk        (clk),
    .rst_n      (rst_n),
    .go_i       (eng_go),
    .rd_i       (eng_rd),
    .tx_byte_i  (eng_tx),
    .rom_din_i  (rom_din_i),
    .rom_clk_o  (rom_clk_o),
    .rom_dout_o (rom_dout_o),
    .rx_byte_o  (eng_rx),
    .done_o     (eng_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      off_q   <= '0;
      left_q  <= '0;
      hidx_q  <= '0;
      grant_q <= 1'b0;
      park_q  <= 1'b1;
      valid_q <= 1'b0;
      done_q  <= 1'b0;
      data_q  <= '0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        S_IDLE: if (start_take) begin
          off_q   <= offset_i;
          left_q  <= count_i;
          hidx_q  <= '0;
          grant_q <= 1'b1;
          st_q    <= S_OPEN1;
        end
        S_OPEN1: if (hs_tick) begin
          park_q <= 1'b0;
          st_q   <= S_OPEN2;
        end
        S_OPEN2: if (hs_tick) begin
          if (left_q == '0) begin
            park_q <= 1'b1;
            st_q   <= S_CLOSE;
          end else begin
            st_q <= S_HDR;
          end
        end
        S_HDR: st_q <= S_HDR_WAIT;
        S_HDR_WAIT: if (eng_done) begin
          if (hidx_q == 2'd2) st_q <= S_RD;
          else begin
            hidx_q <= hidx_q + 1'b1;
            st_q   <= S_HDR;
          end
        end
        S_RD: st_q <= S_RD_WAIT;
        S_RD_WAIT: if (eng_done) begin
          data_q  <= eng_rx;
          valid_q <= 1'b1;
          st_q    <= S_PRESENT;
        end
        S_PRESENT: if (accept) begin
          valid_q <= 1'b0;
          left_q  <= left_q - 1'b1;
          if (last_byte) begin
            park_q <= 1'b1;
            st_q   <= S_CLOSE;
          end else begin
            st_q <= S_RD;
          end
        end
        S_CLOSE: if (hs_tick) begin
          grant_q <= 1'b0;
          done_q  <= 1'b1;
          st_q    <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign rom_grant_o  = grant_q;
  assign rom_park_o   = park_q;
  assign byte_valid_o = valid_q;
  assign byte_data_o  = data_q;
  assign done_o       = done_q;

  assert_no_clk_closed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !access_open |-> !rom_clk_o);

  assert_park_drop_needs_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rom_park_o) |-> rom_grant_o && $past(rom_grant_o));

  assert_grant_drop_after_park_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rom_grant_o) |-> rom_park_o && $past(rom_park_o));

  assert_done_closed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !rom_grant_o && rom_park_o && !rom_clk_o);

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_valid_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid_o && !byte_ready_i |=> byte_valid_o && $stable(byte_data_o));

  assert_no_clk_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid_o |-> !rom_clk_o);

  assert_ignore_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && (st_q != S_IDLE) |=> $stable(off_q));

endmodule

// File: tb/serial_rom_reader_tb.sv
module serial_rom_reader_tb;
  localparam int P  = 3;
  localparam int CW = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [15:0] offset_i = '0;
  logic [CW-1:0] count_i = '0;
  logic byte_ready_i = 1'b0;
  logic rom_din_i = 1'b0;
  logic rom_clk_o, rom_dout_o, rom_grant_o, rom_park_o;
  logic byte_valid_o, done_o;
  logic [7:0] byte_data_o;

  always #2 clk = ~clk;

  serial_rom_reader #(.PHASE_CYC(P), .CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .offset_i(offset_i),
    .count_i(count_i), .byte_ready_i(byte_ready_i), .rom_din_i(rom_din_i),
    .rom_clk_o(rom_clk_o), .rom_dout_o(rom_dout_o), .rom_grant_o(rom_grant_o),
    .rom_park_o(rom_park_o), .byte_valid_o(byte_valid_o),
    .byte_data_o(byte_data_o), .done_o(done_o)
  );

  int checks = 0;
  int fails  = 0;

  function automatic logic [7:0] romval(input logic [15:0] a);
    logic [7:0] m;
    m = a[7:0] * 8'd29;
    return m ^ a[15:8] ^ 8'h3C;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // EEPROM model: header captured on rising clock, data driven on falling clock.
  logic [23:0] hdr;
  int rbits;
  always @(posedge rom_clk_o) begin
    if (rbits < 24) hdr <= {hdr[22:0], rom_dout_o};
    rbits <= rbits + 1;
  end
  always @(negedge rom_clk_o) begin
    if (rbits >= 24) begin
      int idx;
      logic [7:0] v;
      idx = rbits - 24;
      v = romval(hdr[15:0] + 16'(idx / 8));
      rom_din_i <= v[7 - (idx % 8)];
    end
  end

  // Port monitor, sampled on the falling system clock.
  int cyc = 0, mode = 0, ncap = 0, ndone = 0, done_bad = 0;
  int hcnt = 0, badw = 0, badd = 0;
  int t_hr = 0, t_lf = 0, t_lr = 0, t_hf = 0, edge_bad = 0;
  logic [7:0] cap [0:15];
  logic p_clk = 0, p_dout = 0, p_hi = 0, p_lo = 1;

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
    if (rst_n) begin
      case (mode)
        0: byte_ready_i = 1'b1;
        1: byte_ready_i = ~byte_ready_i;
        default: byte_ready_i = (cyc % 3) == 0;
      endcase
      if (byte_valid_o && byte_ready_i && ncap < 16) begin
        cap[ncap] = byte_data_o;
        ncap++;
      end
      if (done_o) begin
        ndone++;
        if (rom_grant_o || !rom_park_o) done_bad++;
      end
      if (rom_clk_o) hcnt++;
      else if (p_clk) begin
        if (hcnt != P) badw++;
        hcnt = 0;
      end
      if (rom_clk_o && p_clk && rom_dout_o != p_dout) badd++;
      if (rom_grant_o && !p_hi) begin t_hr = cyc; if (!rom_park_o || rom_clk_o) edge_bad++; end
      if (!rom_park_o && p_lo)  begin t_lf = cyc; if (!rom_grant_o || rom_clk_o) edge_bad++; end
      if (rom_park_o && !p_lo)  begin t_lr = cyc; if (!rom_grant_o || rom_clk_o) edge_bad++; end
      if (!rom_grant_o && p_hi) begin t_hf = cyc; if (!rom_park_o || rom_clk_o) edge_bad++; end
    end
    p_clk = rom_clk_o; p_dout = rom_dout_o; p_hi = rom_grant_o; p_lo = rom_park_o;
  end

  task automatic run_txn(input logic [15:0] off, input int cnt, input int m,
                         input bit inject);
    int guard;
    @(negedge clk);
    ncap = 0; ndone = 0; done_bad = 0; badw = 0; badd = 0; edge_bad = 0;
    rbits = 0; hdr = '0; mode = m;
    start_i = 1'b1; offset_i = off; count_i = CW'(cnt);
    @(negedge clk);
    start_i = 1'b0;
    if (inject) begin
      repeat (40) @(negedge clk);
      start_i = 1'b1; offset_i = ~off; count_i = CW'(cnt + 2);
      @(negedge clk);
      start_i = 1'b0;
    end
    guard = 0;
    while (ndone == 0 && guard < 20000) begin @(negedge clk); guard++; end
    repeat (12) @(negedge clk);

    chk(t_lf - t_hr == P, "R2", "open gap", t_lf - t_hr, P);
    chk(edge_bad == 0, "R2", "access edge with clock high or wrong order", edge_bad, 0);
    chk(t_hf - t_lr == P, "R9", "close gap", t_hf - t_lr, P);
    chk(ndone == 1, inject ? "R10" : "R9", "done pulses", ndone, 1);
    chk(done_bad == 0, "R9", "done while open", done_bad, 0);
    chk(badw == 0, "R6", "high phase width errors", badw, 0);
    chk(badd == 0, "R4", "dout moved while clock high", badd, 0);
    if (cnt == 0) begin
      chk(rbits == 0, "R11", "bits clocked on zero count", rbits, 0);
      chk(ncap == 0, "R11", "bytes on zero count", ncap, 0);
    end else begin
      chk(hdr[23:16] == 8'h03, "R3", "command byte", hdr[23:16], 8'h03);
      chk(hdr[15:0] == off, inject ? "R10" : "R3", "address", hdr[15:0], off);
      chk(rbits == 8 * (3 + cnt), "R7", "clock pulses", rbits, 8 * (3 + cnt));
      chk(ncap == cnt, inject ? "R10" : "R7", "bytes received", ncap, cnt);
      for (int i = 0; i < cnt && i < 16; i++)
        chk(cap[i] == romval(off + 16'(i)), m != 0 ? "R8" : "R5", "read byte",
            cap[i], romval(off + 16'(i)));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(rom_clk_o == 1'b0, "R1", "reset clock", rom_clk_o, 0);
    chk(rom_grant_o == 1'b0, "R1", "reset grant", rom_grant_o, 0);
    chk(rom_park_o == 1'b1, "R1", "reset park", rom_park_o, 1);
    chk(byte_valid_o == 1'b0, "R1", "reset valid", byte_valid_o, 0);
    chk(done_o == 1'b0, "R1", "reset done", done_o, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // Sweep counts and offsets under every backpressure mode.
    for (int c = 0; c <= 5; c++)
      for (int m = 0; m < 3; m++)
        run_txn(16'(16'h1357 * (c + 1) + 16'(m * 16'h0F1)), c, m, 1'b0);
    run_txn(16'hFFFE, 4, 0, 1'b0);   // R7 address wrap
    run_txn(16'h0000, 1, 1, 1'b0);
    run_txn(16'hFFFF, 0, 2, 1'b0);   // R11
    run_txn(16'hA5C3, 3, 2, 1'b1);   // R10 start during busy
    run_txn(16'h00FF, 2, 1, 1'b1);   // R10

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule